// File: doc/BRIEF.md
# Multiplierless Shift-Add FIR Filter

A six-tap FIR filter with fixed coefficients. The taps are h = {3, 14, 27, 27, 14, 3}. The filter accepts one signed sample per clock, marked by a valid strobe. It returns one full-precision result per clock after a fixed latency. There are no general multipliers. The three distinct products 3x, 14x and 27x come from one small shift-and-add network. That network builds 3x once and reuses it for the other two constants. The products then feed a transposed accumulator chain, which works as the tap delay line.

Every adder in the network ends in a register. Balancing registers align the terms that enter each adder, so that they all belong to the same sample. The filter therefore takes a new sample every clock and never stalls. A cycle with the strobe low counts as a zero sample. The output keeps flowing, and `out_valid` marks only the results that belong to a strobed sample.

Top module: `shift_add_fir`

## Requirements
- R1: `out_data` equals the sum over k = 0..5 of h[k]·x[n-k], with h = {3, 14, 27, 27, 14, 3}. Here x is the two's-complement value of `in_data` captured on a clock edge. The result for the sample captured on edge e is visible after edge e+2, which gives three register stages.
- R2: `out_valid` is high after edge e+2 exactly when `in_valid` was high at capture edge e, and is low otherwise.
- R3: `out_data` is DW + ceil(log2(88)) bits wide, which is 19 bits for DW = 12, in two's complement. A sustained input of -2048 settles at exactly -180224, and a sustained input of 2047 settles at exactly 180136, with no wrap.
- R4: While the synchronous active-high `rst` is sampled high, every register clears. After the reset edge, `out_valid` and `out_data` read 0. No sample captured before the reset contributes to any later output.
- R5: On an edge where `in_valid` is low, `in_data` is ignored and enters the filter as zero. After nine such edges in a row, `out_data` reads 0.
- R6: A single strobed sample v, surrounded by unstrobed cycles, produces 3v, 14v, 27v, 27v, 14v and 3v on six consecutive cycles. `out_valid` is high only on the first of these cycles.
- R7: A strobed sample is accepted on every clock with no stall. Back-to-back samples produce back-to-back valid results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result belongs to a strobed sample |
| out_data | output | DW+7 | Signed filter output, full precision |

## Verification
Assertions check several properties on every cycle. These are the three-edge valid latency in both polarities, the cleared outputs after reset, the output staying inside ±88·2^(DW-1), and a zero output after a long unstrobed stretch. Only the bench scenarios can show the filter's values. These include the exact convolution sums, the impulse response shape, the settled extremes at full scale, and that no sample leaks through a mid-stream reset. The bench compares each of them with a software convolution over random and directed streams.

// File: rtl/shift_add_fir.sv
module shift_add_fir #(
  parameter int DW = 12,
  localparam int NTAP = 6,
  localparam int HSUM = 3 + 14 + 27 + 27 + 14 + 3,
  localparam int OW = DW + $clog2(HSUM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);

  localparam int H [NTAP] = '{3, 14, 27, 27, 14, 3};
  localparam int VLAT = 3;

  logic signed [OW-1:0] xs;
  logic signed [OW-1:0] x1, p3;
  logic signed [OW-1:0] p3d, p14, p27;
  logic signed [OW-1:0] prod [NTAP];
  logic signed [OW-1:0] acc  [NTAP];
  logic [VLAT-1:0]      vpipe;

  assign xs = in_valid ? {{(OW-DW){in_data[DW-1]}}, in_data} : '0;

  // stage 1: shared 3x, balancing copy of x
  always_ff @(posedge clk) begin
    if (rst) begin
      x1 <= '0;
      p3 <= '0;
    end else begin
      x1 <= xs;
      p3 <= xs + (xs <<< 1);
    end
  end

  // stage 2: 14x = 12x + 2x, 27x = 24x + 3x, balancing copy of 3x
  always_ff @(posedge clk) begin
    if (rst) begin
      p3d <= '0;
      p14 <= '0;
      p27 <= '0;
    end else begin
      p3d <= p3;
      p14 <= (p3 <<< 2) + (x1 <<< 1);
      p27 <= (p3 <<< 3) + p3;
    end
  end

  // transposed accumulator chain
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (H[k] == 3) begin : g_c3
      assign prod[k] = p3d;
    end else if (H[k] == 14) begin : g_c14
      assign prod[k] = p14;
    end else begin : g_c27
      assign prod[k] = p27;
    end

    if (k == NTAP - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else     acc[k] <= prod[k];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else     acc[k] <= acc[k+1] + prod[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[VLAT-2:0], in_valid};
  end

  assign out_data  = acc[0];
  assign out_valid = vpipe[VLAT-1];

endmodule

// File: rtl/shift_add_fir_chk.sv
module shift_add_fir_chk #(
  parameter int DW = 12,
  localparam int OW = DW + 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_data,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data
);

  localparam int LIM = 88 * (2 ** (DW - 1));

  logic [3:0] quiet;

  always_ff @(posedge clk) begin
    if (rst)                 quiet <= 4'd9;
    else if (in_valid)       quiet <= '0;
    else if (quiet != 4'd15) quiet <= quiet + 4'd1;
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);

  p_invalid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid);

  p_reset_clear_r4: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(out_data) <= LIM) && (int'(out_data) >= -LIM));

  p_quiet_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 4'd9) |-> (out_data == '0));

endmodule

bind shift_add_fir shift_add_fir_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_shift_add_fir.sv
module tb_shift_add_fir;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int OW = DW + 7;
  localparam int HIST = 9;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic signed [DW-1:0] in_data;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int hist [HIST];
  bit vh [HIST];
  int coef [6] = '{3, 14, 27, 27, 14, 3};

  shift_add_fir #(.DW(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expect_data();
    int s = 0;
    for (int k = 0; k < 6; k++) s += coef[k] * hist[k+2];
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < HIST; k++) begin hist[k] = 0; vh[k] = 1'b0; end
  endtask

  task automatic step(input bit v, input int d, input string tag);
    in_valid = v;
    in_data  = d[DW-1:0];
    for (int k = HIST-1; k > 0; k--) begin hist[k] = hist[k-1]; vh[k] = vh[k-1]; end
    hist[0] = v ? d : 0;
    vh[0]   = v;
    @(negedge clk);
    check(int'(out_data) == expect_data(), tag, int'(out_data), expect_data());
    check(out_valid == vh[2], "R2", int'(out_valid), int'(vh[2]));
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = DW'(rnd_sample());
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_model();
    check(out_valid == 1'b0 && out_data == '0, "R4", int'(out_data), 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    clear_model();
    @(negedge clk);
    do_reset();

    step(1'b1, 1, "R6");
    for (int i = 0; i < 8; i++) step(1'b0, 0, "R6");
    step(1'b1, -5, "R6");
    for (int i = 0; i < 8; i++) step(1'b0, rnd_sample(), "R5");

    for (int i = 0; i < 200; i++) step(1'b1, rnd_sample(), "R7");

    for (int i = 0; i < 12; i++) step(1'b1, -2048, "R3");
    check(int'(out_data) == -180224, "R3", int'(out_data), -180224);
    for (int i = 0; i < 12; i++) step(1'b1, 2047, "R3");
    check(int'(out_data) == 180136, "R3", int'(out_data), 180136);

    for (int i = 0; i < 5; i++) step(1'b1, 2047, "R1");
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b0, rnd_sample(), "R4");

    for (int i = 0; i < 2000; i++)
      step(($urandom_range(0, 3) != 0), rnd_sample(), "R1");

    for (int i = 0; i < 10; i++) step(1'b0, rnd_sample(), "R5");
    check(out_data == '0, "R5", int'(out_data), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule